// File: doc/BRIEF.md
# Serial Port with Sticky Event Interrupt

The block is a byte-wide asynchronous serial port on a plain 32-bit word-addressed register bus. One write to the data word sends a byte on `txd` as a frame with one start bit, eight data bits sent least significant bit first, and one stop bit. Every bit lasts the programmed divisor plus one clock cycles. A receiver watches `rxd`, takes the middle of each bit, and places each complete byte in the data word.

Two sticky flags in the status word record events. One marks that a transmitted frame has finished. The other marks that a received byte is waiting. Software clears a flag by writing a one to its bit. A single level interrupt is raised while an enabled flag is set. While a received byte is waiting, any further incoming byte is discarded. The transmitter-empty bit always reads as one.

Top module: `evt_uart`

## Requirements
- R1: After reset, the data, divisor, control and debug words read 0, the status word reads 0x1, `txd` is 1 and `irq` is 0.
- R2: The word index is bus byte address >> 2, and the two low address bits are ignored. Index 0 is data, 1 is divisor, 2 is status, 3 is control and 4 is debug. Any other index reads 0, and a write to it changes nothing.
- R3: The control and debug words store all 32 written bits and read them back. The divisor word stores and returns the low 16 bits, and the upper bits read 0.
- R4: Status bit 0 (transmitter empty) always reads 1. No write changes it.
- R5: A data write while the transmitter is idle sends bits 7:0 as an 8N1 frame, least significant bit first. Each bit lasts divisor+1 cycles. `txd` idles at 1.
- R6: Status bit 2 (transmit event) is set when the stop bit of a frame ends, and not before. A data write that arrives while a frame is in progress sends nothing and sets no event.
- R7: A correctly framed byte on `rxd`, at divisor+1 cycles per bit, is stored in data bits 7:0 and sets status bit 1 (receive event).
- R8: While status bit 1 is set, a newly received byte is discarded, and the data word keeps the byte it already holds.
- R9: A status write clears bit 1 and/or bit 2 where the written value has a one, and leaves them alone where it has a zero. If an event sets its bit in the same cycle that a write clears it, the bit stays set.
- R10: `irq` equals (control bit 0 AND status bit 1) OR (control bit 1 AND status bit 2). It follows each register change in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe, one per cycle |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word (combinational) |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq | output | 1 | Level interrupt request |

## Verification
Two things can land in the same cycle: the end of a transmitted frame setting the transmit event, and a software write that clears that same bit. The bench counts cycles from the data write to the exact edge where the event is set, and it makes its clearing status write land on that edge. A read of status bit 2 straight afterwards must show it still set. A second case checks the receive side: bytes that arrive while a byte is still pending must leave the stored data unchanged.

// File: rtl/evt_uart_pkg.sv
package evt_uart_pkg;

    // word indices of the register map (bus byte address >> 2)
    localparam int IDX_DATA = 0;
    localparam int IDX_DIV  = 1;
    localparam int IDX_STAT = 2;
    localparam int IDX_CTRL = 3;
    localparam int IDX_DBG  = 4;

    // status word bit positions
    localparam int ST_EMPTY = 0;
    localparam int ST_RXEV  = 1;
    localparam int ST_TXEV  = 2;

    // control word bit positions
    localparam int CT_RXIE  = 0;
    localparam int CT_TXIE  = 1;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_phase_e;

endpackage

// File: rtl/evt_uart_tx.sv
module evt_uart_tx #(
    parameter int DIV_W     = 16,
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [DATA_BITS-1:0] byte_in,
    input  logic [DIV_W-1:0]     div,
    output logic                 txd,
    output logic                 busy,
    output logic                 done
);
    localparam int FRAME_W = DATA_BITS + 2;
    localparam int CNT_W   = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

    typedef struct packed {
        logic               busy;
        logic [FRAME_W-1:0] frame;
        logic [CNT_W-1:0]   bit_n;
        logic [DIV_W-1:0]   tick;
        logic               done;
    } tx_st_t;

    localparam tx_st_t TX_RST = '{busy: 1'b0, frame: '1, bit_n: '0, tick: '0, done: 1'b0};

    tx_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy  = 1'b1;
                st_d.frame = {1'b1, byte_in, 1'b0};
                st_d.bit_n = '0;
                st_d.tick  = div;
            end
        end else if (st_q.tick == '0) begin
            st_d.tick = div;
            if (st_q.bit_n == LAST_BIT) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.frame = {1'b1, st_q.frame[FRAME_W-1:1]};
                st_d.bit_n = st_q.bit_n + 1'b1;
            end
        end else begin
            st_d.tick = st_q.tick - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TX_RST;
        else        st_q <= st_d;
    end

    assign txd  = st_q.busy ? st_q.frame[0] : 1'b1;
    assign busy = st_q.busy;
    assign done = st_q.done;

endmodule

// File: rtl/evt_uart_rx.sv
module evt_uart_rx
    import evt_uart_pkg::*;
#(
    parameter int DIV_W     = 16,
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rxd,
    input  logic [DIV_W-1:0]     div,
    output logic                 byte_valid,
    output logic [DATA_BITS-1:0] byte_out
);
    localparam int CNT_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_BITS - 1);

    typedef struct packed {
        logic [2:0]           sh;      // [0],[1] synchroniser, [2] previous line
        rx_phase_e            phase;
        logic [DIV_W-1:0]     tick;
        logic [CNT_W-1:0]     bit_n;
        logic [DATA_BITS-1:0] shreg;
        logic                 valid;
        logic [DATA_BITS-1:0] data;
    } rx_st_t;

    localparam rx_st_t RX_RST = '{sh: 3'b111, phase: RX_IDLE, tick: '0, bit_n: '0,
                                  shreg: '0, valid: 1'b0, data: '0};

    rx_st_t st_d, st_q;
    logic   line;

    assign line = st_q.sh[1];

    always_comb begin
        st_d       = st_q;
        st_d.sh    = {st_q.sh[1:0], rxd};
        st_d.valid = 1'b0;
        unique case (st_q.phase)
            RX_IDLE: begin
                if (st_q.sh[2] && !line) begin
                    st_d.phase = RX_START;
                    st_d.tick  = div >> 1;
                end
            end
            RX_START: begin
                if (st_q.tick == '0) begin
                    if (!line) begin
                        st_d.phase = RX_DATA;
                        st_d.tick  = div;
                        st_d.bit_n = '0;
                    end else begin
                        st_d.phase = RX_IDLE;
                    end
                end else begin
                    st_d.tick = st_q.tick - 1'b1;
                end
            end
            RX_DATA: begin
                if (st_q.tick == '0) begin
                    st_d.shreg = {line, st_q.shreg[DATA_BITS-1:1]};
                    st_d.tick  = div;
                    if (st_q.bit_n == LAST_BIT) st_d.phase = RX_STOP;
                    else                        st_d.bit_n = st_q.bit_n + 1'b1;
                end else begin
                    st_d.tick = st_q.tick - 1'b1;
                end
            end
            RX_STOP: begin
                if (st_q.tick == '0) begin
                    st_d.phase = RX_IDLE;
                    if (line) begin
                        st_d.valid = 1'b1;
                        st_d.data  = st_q.shreg;
                    end
                end else begin
                    st_d.tick = st_q.tick - 1'b1;
                end
            end
            default: st_d.phase = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RX_RST;
        else        st_q <= st_d;
    end

    assign byte_valid = st_q.valid;
    assign byte_out   = st_q.data;

endmodule

// File: rtl/evt_uart_regs.sv
module evt_uart_regs
    import evt_uart_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int DIV_W     = 16,
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [ADDR_W-3:0]    widx,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    input  logic                 rx_valid,
    input  logic [DATA_BITS-1:0] rx_byte,
    input  logic                 tx_done,
    output logic                 tx_start,
    output logic [DATA_BITS-1:0] tx_byte,
    output logic [DIV_W-1:0]     div,
    output logic                 irq,
    output logic                 rx_ev,
    output logic                 tx_ev,
    output logic [DATA_BITS-1:0] rx_data
);
    localparam int WIDX_W = ADDR_W - 2;
    localparam logic [WIDX_W-1:0] W_DATA = WIDX_W'(IDX_DATA);
    localparam logic [WIDX_W-1:0] W_DIV  = WIDX_W'(IDX_DIV);
    localparam logic [WIDX_W-1:0] W_STAT = WIDX_W'(IDX_STAT);
    localparam logic [WIDX_W-1:0] W_CTRL = WIDX_W'(IDX_CTRL);
    localparam logic [WIDX_W-1:0] W_DBG  = WIDX_W'(IDX_DBG);

    typedef struct packed {
        logic [DATA_BITS-1:0] data;
        logic [DIV_W-1:0]     div;
        logic                 rx_ev;
        logic                 tx_ev;
        logic [DATA_W-1:0]    ctrl;
        logic [DATA_W-1:0]    dbg;
    } reg_st_t;

    localparam reg_st_t REG_RST = '{data: '0, div: '0, rx_ev: 1'b0, tx_ev: 1'b0,
                                   ctrl: '0, dbg: '0};

    reg_st_t st_d, st_q;
    logic    wr_stat;

    assign wr_stat = wr && (widx == W_STAT);

    always_comb begin
        st_d = st_q;
        if (wr) begin
            unique case (widx)
                W_DIV:   st_d.div  = wdata[DIV_W-1:0];
                W_CTRL:  st_d.ctrl = wdata;
                W_DBG:   st_d.dbg  = wdata;
                default: ;
            endcase
        end
        // write-one-to-clear first, hardware set afterwards so set wins
        if (wr_stat && wdata[ST_RXEV]) st_d.rx_ev = 1'b0;
        if (wr_stat && wdata[ST_TXEV]) st_d.tx_ev = 1'b0;
        if (rx_valid && !st_q.rx_ev) begin
            st_d.data  = rx_byte;
            st_d.rx_ev = 1'b1;
        end
        if (tx_done) st_d.tx_ev = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= REG_RST;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        unique case (widx)
            W_DATA:  rdata = DATA_W'(st_q.data);
            W_DIV:   rdata = DATA_W'(st_q.div);
            W_STAT: begin
                rdata[ST_EMPTY] = 1'b1;
                rdata[ST_RXEV]  = st_q.rx_ev;
                rdata[ST_TXEV]  = st_q.tx_ev;
            end
            W_CTRL:  rdata = st_q.ctrl;
            W_DBG:   rdata = st_q.dbg;
            default: rdata = '0;
        endcase
    end

    assign tx_start = wr && (widx == W_DATA);
    assign tx_byte  = wdata[DATA_BITS-1:0];
    assign div      = st_q.div;
    assign irq      = (st_q.ctrl[CT_RXIE] && st_q.rx_ev) || (st_q.ctrl[CT_TXIE] && st_q.tx_ev);
    assign rx_ev    = st_q.rx_ev;
    assign tx_ev    = st_q.tx_ev;
    assign rx_data  = st_q.data;

endmodule

// File: rtl/evt_uart.sv
module evt_uart #(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int DIV_W     = 16,
    parameter int DATA_BITS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rxd,
    output logic              txd,
    output logic              irq
);
    logic                 tx_start, tx_busy, tx_done;
    logic [DATA_BITS-1:0] tx_byte;
    logic                 rx_valid;
    logic [DATA_BITS-1:0] rx_byte;
    logic [DIV_W-1:0]     div;
    logic                 rx_ev, tx_ev;
    logic [DATA_BITS-1:0] rx_data;

    evt_uart_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W), .DATA_BITS(DATA_BITS)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bus_wr),
        .widx     (bus_addr[ADDR_W-1:2]),
        .wdata    (bus_wdata),
        .rdata    (bus_rdata),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .tx_done  (tx_done),
        .tx_start (tx_start),
        .tx_byte  (tx_byte),
        .div      (div),
        .irq      (irq),
        .rx_ev    (rx_ev),
        .tx_ev    (tx_ev),
        .rx_data  (rx_data)
    );

    evt_uart_tx #(.DIV_W(DIV_W), .DATA_BITS(DATA_BITS)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tx_start),
        .byte_in (tx_byte),
        .div     (div),
        .txd     (txd),
        .busy    (tx_busy),
        .done    (tx_done)
    );

    evt_uart_rx #(.DIV_W(DIV_W), .DATA_BITS(DATA_BITS)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .rxd        (rxd),
        .div        (div),
        .byte_valid (rx_valid),
        .byte_out   (rx_byte)
    );

endmodule

// File: rtl/evt_uart_chk.sv
module evt_uart_chk #(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int DATA_BITS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_wr,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [DATA_W-1:0]    bus_wdata,
    input logic [DATA_W-1:0]    bus_rdata,
    input logic                 txd,
    input logic                 irq,
    input logic                 tx_busy,
    input logic                 tx_done,
    input logic                 rx_ev,
    input logic                 tx_ev,
    input logic [DATA_BITS-1:0] rx_data
);
    localparam int WIDX_W = ADDR_W - 2;
    localparam logic [WIDX_W-1:0] W_STAT = WIDX_W'(2);
    localparam logic [WIDX_W-1:0] W_LAST = WIDX_W'(4);

    logic [WIDX_W-1:0] widx;
    logic              clr_rx, clr_tx;

    assign widx   = bus_addr[ADDR_W-1:2];
    assign clr_rx = bus_wr && (widx == W_STAT) && bus_wdata[1];
    assign clr_tx = bus_wr && (widx == W_STAT) && bus_wdata[2];

    p_unmapped_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (widx > W_LAST) |-> (bus_rdata == '0));

    p_empty_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (widx == W_STAT) |-> bus_rdata[0]);

    p_idle_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd);

    p_txev_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_ev) |-> $past(tx_done));

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> !tx_done);

    p_rx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ev && !clr_rx) |=> $stable(rx_data));

    p_w1c_tx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_tx && !tx_done) |=> !tx_ev);

    p_irq_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (rx_ev || tx_ev));

endmodule

bind evt_uart evt_uart_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DATA_BITS(DATA_BITS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .txd       (txd),
    .irq       (irq),
    .tx_busy   (tx_busy),
    .tx_done   (tx_done),
    .rx_ev     (rx_ev),
    .tx_ev     (tx_ev),
    .rx_data   (rx_data)
);

// File: tb/evt_uart_bench.sv
module evt_uart_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rxd = 1'b1;
    logic        txd;
    logic        irq;

    int total = 0;
    int bad = 0;
    int frames = 0;
    int cur_div = 0;
    logic [7:0] exp_q[$];

    always #5 clk = ~clk;

    evt_uart u_evt_uart (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rxd(rxd), .txd(txd), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic expect_rd(input logic [7:0] a, input logic [31:0] e, input string req);
        logic [31:0] v;
        reg_rd(a, v);
        chk(v == e, req, v, e);
    endtask

    task automatic send_tx(input logic [7:0] b);
        exp_q.push_back(b);
        reg_wr(8'h00, {24'h0, b});
    endtask

    task automatic send_rx(input logic [7:0] b);
        @(negedge clk);
        rxd = 1'b0;
        repeat (cur_div + 1) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (cur_div + 1) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (cur_div + 3) @(negedge clk);
    endtask

    task automatic wait_frame();
        repeat (11 * (cur_div + 1) + 6) @(negedge clk);
    endtask

    // monitor: decodes txd and compares against the scoreboard queue (R5)
    initial begin
        logic [7:0] got;
        logic       stop_b;
        logic [7:0] e;
        forever begin
            @(negedge clk);
            if (rst_n && txd === 1'b0) begin
                repeat (cur_div / 2) @(negedge clk);
                got = '0;
                for (int i = 0; i < 8; i++) begin
                    repeat (cur_div + 1) @(negedge clk);
                    got[i] = txd;
                end
                repeat (cur_div + 1) @(negedge clk);
                stop_b = txd;
                frames++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6 unexpected frame", {24'h0, got}, 32'h0);
                end else begin
                    e = exp_q.pop_front();
                    chk(got == e && stop_b == 1'b1, "R5 frame content", {23'h0, stop_b, got}, {23'h0, 1'b1, e});
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 32'h0, 32'h1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        expect_rd(8'h00, 32'h0, "R1 data");
        expect_rd(8'h04, 32'h0, "R1 divisor");
        expect_rd(8'h08, 32'h1, "R1 status");
        expect_rd(8'h0C, 32'h0, "R1 control");
        expect_rd(8'h10, 32'h0, "R1 debug");
        chk(txd == 1'b1 && irq == 1'b0, "R1 txd/irq", {30'h0, txd, irq}, 32'h2);

        // R3 storage words
        reg_wr(8'h04, 32'hFFFF_0007);
        cur_div = 7;
        expect_rd(8'h04, 32'h0000_0007, "R3 divisor low bits");
        reg_wr(8'h10, 32'h8000_0001);
        expect_rd(8'h10, 32'h8000_0001, "R3 debug");
        reg_wr(8'h0C, 32'hA5A5_0004);
        expect_rd(8'h0C, 32'hA5A5_0004, "R3 control");
        reg_wr(8'h0C, 32'h0);

        // R2 decoding
        reg_wr(8'h14, 32'hDEAD_BEEF);
        expect_rd(8'h14, 32'h0, "R2 unmapped 0x14");
        expect_rd(8'h1C, 32'h0, "R2 unmapped 0x1C");
        expect_rd(8'h06, 32'h7, "R2 low address bits ignored");
        expect_rd(8'h10, 32'h8000_0001, "R2 unmapped write harmless");

        // R4 empty flag stays set
        reg_wr(8'h08, 32'hFFFF_FFFF);
        expect_rd(8'h08, 32'h1, "R4 status after all-ones write");

        // R5/R6 transmit, ignored write while busy
        send_tx(8'h3C);
        repeat (20) @(negedge clk);
        reg_wr(8'h00, 32'h99);
        expect_rd(8'h08, 32'h1, "R6 no event mid frame");
        wait_frame();
        expect_rd(8'h08, 32'h5, "R6 event after stop");
        chk(frames == 1, "R6 write while busy ignored", frames, 1);
        chk(irq == 1'b0, "R10 disabled irq low", {31'h0, irq}, 32'h0);

        // R10 enable transmit interrupt
        reg_wr(8'h0C, 32'h2);
        chk(irq == 1'b1, "R10 tx irq raised", {31'h0, irq}, 32'h1);

        // R9 selective clear
        reg_wr(8'h08, 32'h2);
        expect_rd(8'h08, 32'h5, "R9 zero bit leaves tx event");
        reg_wr(8'h08, 32'h4);
        expect_rd(8'h08, 32'h1, "R9 tx event cleared");
        chk(irq == 1'b0, "R10 irq drops after clear", {31'h0, irq}, 32'h0);

        // R9 collision: clear lands on the edge the event is set
        send_tx(8'h5A);
        repeat (10 * (cur_div + 1) - 1) @(negedge clk);
        reg_wr(8'h08, 32'h4);
        expect_rd(8'h08, 32'h5, "R9 set wins over clear");
        reg_wr(8'h08, 32'h4);
        repeat (4) @(negedge clk);

        // R7 receive
        reg_wr(8'h0C, 32'h1);
        send_rx(8'hA7);
        expect_rd(8'h00, 32'hA7, "R7 received byte");
        expect_rd(8'h08, 32'h3, "R7 receive event");
        chk(irq == 1'b1, "R10 rx irq raised", {31'h0, irq}, 32'h1);

        // R8 discard while pending
        send_rx(8'h4E);
        expect_rd(8'h00, 32'hA7, "R8 data kept while pending");
        expect_rd(8'h08, 32'h3, "R8 event still set");

        reg_wr(8'h08, 32'h2);
        expect_rd(8'h08, 32'h1, "R9 rx event cleared");
        chk(irq == 1'b0, "R10 irq low after rx clear", {31'h0, irq}, 32'h0);
        send_rx(8'h4E);
        expect_rd(8'h00, 32'h4E, "R7 byte after clear");

        // second divisor
        reg_wr(8'h08, 32'h6);
        reg_wr(8'h04, 32'h3);
        cur_div = 3;
        send_tx(8'hC3);
        wait_frame();
        send_rx(8'h81);
        expect_rd(8'h00, 32'h81, "R7 byte at divisor 3");
        expect_rd(8'h08, 32'h7, "R6 R7 both events at divisor 3");

        chk(exp_q.size() == 0, "R5 all frames seen", exp_q.size(), 0);
        chk(frames == 3, "R5 frame count", frames, 3);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule